// File: doc/BRIEF.md
# Memory Sleep-State Sequencer

This block steps a synchronous memory into and out of a low-power retention state. Software or a power manager drives an asynchronous sleep request. The block brings that request into the clock domain, then counts a fixed number of clock cycles before it declares the memory asleep. When the request falls, it counts a second fixed window before it lets the memory be accessed again.

From the first cycle of entry until recovery ends, the block tells the access controller to refuse new accesses, and it tells the data-path drivers to keep the shared data bus at high impedance. An access that is still outstanding when entry begins is not honoured.

The caller must keep the memory deselected and both address strobes idle from the moment the request reaches the sequencer until recovery ends. If any of those signals is active in that span, the block raises a violation flag. The flag stays set until reset.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `asleep`, `access_block`, `bus_float` and `proto_err` are all 0. With `sleep_req` tied low, the block remains in the active state.
- R2: While `sleep_req` stays low, `asleep`, `access_block` and `bus_float` stay 0 whatever `sel_any` and `strobe_any` do.
- R3: Let clock edge 0 be the first edge that samples `sleep_req` high. Then `access_block` is 1 from edge 2. `asleep` is 1 from edge 4, provided the request was still high at edges 0, 1 and 2. `asleep` never rises directly from the active state.
- R4: Let edge L be the first edge that samples `sleep_req` low again, for any pulse length L ≥ 1. Then `access_block` stays 1 through edge L+3 and is 0 from edge L+4. `asleep` is 0 from edge L+2. When `asleep` falls, `access_block` is still 1.
- R5: `bus_float` equals `access_block` on every cycle, so the data bus is held at high impedance throughout entry, sleep and recovery, including on exit.
- R6: `proto_err` is set at clock edge j if `sel_any` or `strobe_any` is 1 at that edge while the sequencer is busy (between edge 2 and edge L+3 of a request) or has already synchronised a request (edges 1 to L). In edge terms, j is between 2 and L+4 inclusive. Once set, it stays 1 until reset.
- R7: Activity on `sel_any` or `strobe_any` while the sequencer is idle and no request is being synchronised does not set `proto_err`.
- R8: A request that falls during entry (L of 1 or 2) never raises `asleep`. The block still goes through the full recovery window before releasing `access_block`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous request for the sleep state (1 = sleep) |
| sel_any | input | 1 | 1 when any chip enable selects the memory |
| strobe_any | input | 1 | 1 when either address strobe is active |
| asleep | output | 1 | Memory is in the sleep state |
| access_block | output | 1 | Tells the access controller to refuse new accesses |
| bus_float | output | 1 | Keep the data bus drivers at high impedance |
| proto_err | output | 1 | Sticky flag: enable or strobe activity during entry, sleep or recovery |

## Verification
The embedded properties check, on every cycle, several ordering rules:
- `asleep` can only rise after `access_block` was already high.
- `access_block` is still high when `asleep` falls.
- `access_block` releases only once `asleep` has been low for a cycle.
- `bus_float` follows the blocking signal.
- The violation flag never clears.
- Nothing becomes busy without a synchronised request.

The exact entry and exit latencies for every request pulse length, and the abort path for short pulses, can only be shown by the bench's sweeps. So can the exact window in which enable or strobe activity counts as a violation.

// File: rtl/msleep_pkg.sv
package msleep_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ENTER  = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_EXIT   = 2'd3
    } sleep_st_e;

endpackage

// File: rtl/msleep_req_sync.sv
module msleep_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_o = r_q.chain[STAGES-1];

endmodule

// File: rtl/msleep_fsm.sv
module msleep_fsm
    import msleep_pkg::*;
#(
    parameter int ENTER_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic busy_o,
    output logic asleep_o
);

    localparam int MAX_CYC = (ENTER_CYCLES > EXIT_CYCLES) ? ENTER_CYCLES : EXIT_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(ENTER_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYCLES - 1);

    typedef struct packed {
        sleep_st_e        st;
        logic [CNT_W-1:0] cnt;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_AWAKE: begin
                if (req_i) begin
                    r_d.st  = ST_ENTER;
                    r_d.cnt = '0;
                end
            end
            ST_ENTER: begin
                if (!req_i) begin
                    r_d.st  = ST_EXIT;
                    r_d.cnt = '0;
                end else if (r_q.cnt == ENTER_LAST) begin
                    r_d.st  = ST_ASLEEP;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (!req_i) begin
                    r_d.st  = ST_EXIT;
                    r_d.cnt = '0;
                end
            end
            default: begin
                if (r_q.cnt == EXIT_LAST) begin
                    r_d.st  = ST_AWAKE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_AWAKE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = (r_q.st != ST_AWAKE);
    assign asleep_o = (r_q.st == ST_ASLEEP);

    AST_SLEEP_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep_o) |-> $past(busy_o)); // R3
    AST_NO_DIRECT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !asleep_o); // R3
    AST_EXIT_STILL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep_o) |-> busy_o); // R4
    AST_RELEASE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (!asleep_o && $past(!asleep_o))); // R4
    AST_IDLE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !req_i) |=> !busy_o); // R2

endmodule

// File: rtl/msleep_guard.sv
module msleep_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic req_i,
    input  logic sel_i,
    input  logic strobe_i,
    output logic err_o
);

    typedef struct packed {
        logic err;
    } guard_regs_t;

    guard_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if ((sel_i || strobe_i) && (busy_i || req_i)) r_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign err_o = r_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R6
    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !busy_i && !req_i) |=> !err_o); // R7

endmodule

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl #(
    parameter int SYNC_STAGES  = 2,
    parameter int ENTER_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic sel_any,
    input  logic strobe_any,
    output logic asleep,
    output logic access_block,
    output logic bus_float,
    output logic proto_err
);

    logic req_sync;
    logic busy;

    msleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sleep_req),
        .sync_o  (req_sync)
    );

    msleep_fsm #(.ENTER_CYCLES(ENTER_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_sync),
        .busy_o   (busy),
        .asleep_o (asleep)
    );

    msleep_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy),
        .req_i    (req_sync),
        .sel_i    (sel_any),
        .strobe_i (strobe_any),
        .err_o    (proto_err)
    );

    assign access_block = busy;
    assign bus_float    = busy;

    AST_FLOAT_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (bus_float && access_block)); // R5
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!asleep && !access_block)); // R1

endmodule

// File: tb/test_mem_sleep_ctrl.sv
`timescale 1ns/1ps
module test_mem_sleep_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic sel_any = 1'b0;
    logic strobe_any = 1'b0;
    logic asleep, access_block, bus_float, proto_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mem_sleep_ctrl i_mem_sleep_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .sel_any      (sel_any),
        .strobe_any   (strobe_any),
        .asleep       (asleep),
        .access_block (access_block),
        .bus_float    (bus_float),
        .proto_err    (proto_err)
    );

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        sleep_req = 1'b0; sel_any = 1'b0; strobe_any = 1'b0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        do_reset();
        check("R1 asleep", asleep, 1'b0);
        check("R1 block", access_block, 1'b0);
        check("R1 float", bus_float, 1'b0);
        check("R1 err", proto_err, 1'b0);
        for (int i = 0; i < 6; i++) step();
        check("R1 idle with request low", access_block, 1'b0);

        // R2 and R7: idle activity with request low
        for (int p = 0; p < 16; p++) begin
            sel_any = p[0]; strobe_any = p[1];
            step();
            check("R2 asleep", asleep, 1'b0);
            check("R2 block", access_block, 1'b0);
            check("R7 err", proto_err, 1'b0);
        end
        sel_any = 1'b0; strobe_any = 1'b0;

        // R3 R4 R5 R8: sweep pulse length
        for (int len = 1; len <= 8; len++) begin
            do_reset();
            for (int j = 0; j <= len + 7; j++) begin
                sleep_req = (j < len);
                step();
                check("R3/R4 block", access_block, (j >= 2 && j <= len + 3));
                check(len < 3 ? "R8 asleep" : "R3/R4 asleep", asleep,
                      (j >= 4 && j <= len + 1));
                check("R5 float", bus_float, (j >= 2 && j <= len + 3));
                check("R7 err quiet", proto_err, 1'b0);
            end
        end

        // R6 R7: activity injected at each edge of a request with L = 5
        for (int sel = 0; sel < 2; sel++) begin
            for (int inj = 0; inj <= 12; inj++) begin
                automatic logic exp_err = (inj >= 2 && inj <= 9);
                do_reset();
                for (int j = 0; j <= 12; j++) begin
                    sleep_req  = (j < 5);
                    sel_any    = (sel == 1) && (j == inj);
                    strobe_any = (sel == 0) && (j == inj);
                    step();
                    if (j == inj) check(exp_err ? "R6 set" : "R7 no set", proto_err, exp_err);
                end
                sel_any = 1'b0; strobe_any = 1'b0;
                step(); step();
                check(exp_err ? "R6 sticky" : "R7 stays clear", proto_err, exp_err);
            end
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule